// File: doc/BRIEF.md
# Start/Done Request Crossing Between Two Clock Domains

This block carries a one-bit "begin work" request from a register-write clock domain into a separate worker clock domain. It then carries the "work finished" answer back the other way, so that the request can be cleared. Each domain owns exactly one level. The write side owns the request flag. The worker side owns the done level. Each level reaches the other domain only through its own chain of synchronizer flops. No register is ever written from both clocks.

On the write side, a strobe carrying a data bit of 1 raises the request flag. The flag drops once the synchronized done level is seen. While the flag is up, or while done has not yet returned low, the block reports busy and ignores further writes. On the worker side, the rising edge of the synchronized request produces a single start pulse and loads a down-counter. The counter stands in for a task whose length is set by a parameter. When it expires, the worker raises done and holds it until the synchronized request has gone low. This gives a four-phase handshake.

Top module: `startDoneXing`

## Requirements
- R1: While `rstN` is low, `busy`, `startPulse` and `taskRun` are 0. They go to 0 at once when reset is applied, with no clock edge needed.
- R2: A write (`wrStb`=1 with `wrBit`=1) sampled on a `wrClk` rising edge while `busy` is 0 makes `busy` read 1 right after that edge.
- R3: A write with `wrBit`=0 is ignored. `busy` stays 0 and no `startPulse` appears.
- R4: Each accepted request produces exactly one `startPulse`, one `wkClk` cycle wide. With the default two synchronizer stages, the pulse is high after the second `wkClk` rising edge that follows the flag being set, never earlier.
- R5: `taskRun` is high for exactly `TASK_LEN` consecutive `wkClk` cycles. It starts on the cycle after `startPulse`.
- R6: The request flag is cleared only after the synchronized done level is seen. Done stays high until the synchronized request is low. `busy` is therefore still 1 when `taskRun` falls.
- R7: Writes of 1 while `busy` is 1 are ignored. They cause no second `startPulse`, and `busy` falls once and stays 0.
- R8: After `taskRun` falls, `busy` returns to 0 within 20 `wrClk` cycles. A new request is then accepted and served.
- R9: Applying `rstN` in the middle of a task clears `busy` and `taskRun` at once. After release, a fresh request is served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wkClk | input | 1 | Worker-domain clock |
| rstN | input | 1 | Shared active-low asynchronous reset |
| wrStb | input | 1 | Write strobe, write domain |
| wrBit | input | 1 | Data bit of the write; 1 requests work |
| busy | output | 1 | Write domain: request flag or returning done still active |
| startPulse | output | 1 | Worker domain: one-cycle pulse when a task begins |
| taskRun | output | 1 | Worker domain: high while the stand-in task counts down |

## Verification
On every cycle, the in-line assertions check the local handshake rules. The flag rises only from an accepted write and falls only after done is seen. The start pulse is one cycle wide and is followed by the run state. The request stays high throughout the run, and done falls only after the request has gone away. The counter never exceeds its load value. Some behaviours span both clocks and only the bench scenarios can show them. These are the end-to-end latency through the synchronizers, the exact task length, the turnaround of busy, the rejection of writes over the whole transaction, and recovery after an asynchronous reset in mid-task.

// File: rtl/hsPkg.sv
`timescale 1ns/100ps
package hsPkg;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_RUN  = 2'd1,
    WK_HOLD = 2'd2
  } wkState_e;

  // strobes from worker control to worker datapath
  typedef struct packed {
    logic load;   // load the task length into the counter
    logic step;   // count down one
  } wkStrobe_t;

endpackage

// File: rtl/hsSync.sv
`timescale 1ns/100ps
module hsSync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= '0;
        else       chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= '0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hsReqFlag.sv
`timescale 1ns/100ps
module hsReqFlag (
  input  logic wrClk,
  input  logic rstN,
  input  logic wrStb,
  input  logic wrBit,
  input  logic doneSync,
  output logic reqFlag,
  output logic busy
);

  logic accept;

  // a write of 1 lands only when neither phase of the handshake is active
  assign accept = wrStb && wrBit && !reqFlag && !doneSync;
  assign busy   = reqFlag || doneSync;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)         reqFlag <= 1'b0;
    else if (accept)   reqFlag <= 1'b1;
    else if (doneSync) reqFlag <= 1'b0;
  end

  // flag only rises from a write of 1 seen while done was low
  assert_flag_source_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(reqFlag) |-> $past(wrStb && wrBit && !doneSync));

  // once done is seen, the flag is dropped on the following edge
  assert_flag_clear_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    (reqFlag && doneSync) |=> !reqFlag);

  // returning done blocks any new request
  assert_write_blocked_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    doneSync |=> !$rose(reqFlag));

endmodule

// File: rtl/hsWorkPath.sv
`timescale 1ns/100ps
module hsWorkPath
  import hsPkg::*;
#(
  parameter int TASK_LEN = 8
) (
  input  logic      wkClk,
  input  logic      rstN,
  input  wkStrobe_t strobe,
  output logic      last
);

  localparam int CNT_W = $clog2(TASK_LEN + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge wkClk or negedge rstN) begin
    if (!rstN)                          count <= '0;
    else if (strobe.load)               count <= CNT_W'(TASK_LEN);
    else if (strobe.step && count != 0) count <= count - CNT_W'(1);
  end

  assign last = (count == CNT_W'(1));

  assert_count_bound_R5: assert property (@(posedge wkClk) disable iff (!rstN)
    count <= CNT_W'(TASK_LEN));

  // a load always starts the countdown from the full length
  assert_load_value_R5: assert property (@(posedge wkClk) disable iff (!rstN)
    strobe.load |=> (count == CNT_W'(TASK_LEN)));

endmodule

// File: rtl/hsWorkCtrl.sv
`timescale 1ns/100ps
module hsWorkCtrl
  import hsPkg::*;
(
  input  logic      wkClk,
  input  logic      rstN,
  input  logic      reqSync,
  input  logic      last,
  output wkStrobe_t strobe,
  output logic      startPulse,
  output logic      taskRun,
  output logic      doneLvl
);

  wkState_e state, stateNxt;
  logic     reqPrev;
  logic     reqRise;

  always_ff @(posedge wkClk or negedge rstN) begin
    if (!rstN) reqPrev <= 1'b0;
    else       reqPrev <= reqSync;
  end

  assign reqRise = reqSync && !reqPrev;

  always_comb begin
    stateNxt    = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    unique case (state)
      WK_IDLE: begin
        if (reqRise) begin
          strobe.load = 1'b1;
          stateNxt    = WK_RUN;
        end
      end
      WK_RUN: begin
        strobe.step = 1'b1;
        if (last) stateNxt = WK_HOLD;
      end
      WK_HOLD: begin
        if (!reqSync) stateNxt = WK_IDLE;
      end
      default: stateNxt = WK_IDLE;
    endcase
  end

  always_ff @(posedge wkClk or negedge rstN) begin
    if (!rstN) state <= WK_IDLE;
    else       state <= stateNxt;
  end

  assign startPulse = strobe.load;
  assign taskRun    = (state == WK_RUN);
  assign doneLvl    = (state == WK_HOLD);

  assert_pulse_single_R4: assert property (@(posedge wkClk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_run_follows_R5: assert property (@(posedge wkClk) disable iff (!rstN)
    startPulse |=> taskRun);

  // the write side must not withdraw the request before done
  assert_req_held_R6: assert property (@(posedge wkClk) disable iff (!rstN)
    taskRun |-> reqSync);

  assert_done_release_R6: assert property (@(posedge wkClk) disable iff (!rstN)
    $fell(doneLvl) |-> !$past(reqSync));

  assert_state_legal_R5: assert property (@(posedge wkClk) disable iff (!rstN)
    $onehot0({state == WK_RUN, state == WK_HOLD}) && (state != 2'd3));

endmodule

// File: rtl/startDoneXing.sv
`timescale 1ns/100ps
module startDoneXing
  import hsPkg::*;
#(
  parameter int TASK_LEN    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic wkClk,
  input  logic rstN,
  input  logic wrStb,
  input  logic wrBit,
  output logic busy,
  output logic startPulse,
  output logic taskRun
);

  logic      reqFlag;
  logic      reqSync;
  logic      doneLvl;
  logic      doneSync;
  logic      last;
  wkStrobe_t strobe;

  hsReqFlag u_reqFlag (
    .wrClk    (wrClk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .wrBit    (wrBit),
    .doneSync (doneSync),
    .reqFlag  (reqFlag),
    .busy     (busy)
  );

  hsSync #(.STAGES(SYNC_STAGES), .W(1)) u_reqSync (
    .clk  (wkClk),
    .rstN (rstN),
    .d    (reqFlag),
    .q    (reqSync)
  );

  hsWorkCtrl u_workCtrl (
    .wkClk      (wkClk),
    .rstN       (rstN),
    .reqSync    (reqSync),
    .last       (last),
    .strobe     (strobe),
    .startPulse (startPulse),
    .taskRun    (taskRun),
    .doneLvl    (doneLvl)
  );

  hsWorkPath #(.TASK_LEN(TASK_LEN)) u_workPath (
    .wkClk  (wkClk),
    .rstN   (rstN),
    .strobe (strobe),
    .last   (last)
  );

  hsSync #(.STAGES(SYNC_STAGES), .W(1)) u_doneSync (
    .clk  (wrClk),
    .rstN (rstN),
    .d    (doneLvl),
    .q    (doneSync)
  );

endmodule

// File: tb/startDoneXing_bench.sv
`timescale 1ns/100ps
module startDoneXing_bench;

  localparam int LEN = 6;

  logic wrClk = 1'b0;
  logic wkClk = 1'b0;
  logic rstN  = 1'b0;
  logic wrStb = 1'b0;
  logic wrBit = 1'b0;
  logic busy, startPulse, taskRun;

  int vectors = 0;
  int fails   = 0;
  int pulses  = 0;
  int wideErr = 0;
  bit prevPulse = 1'b0;
  bit finished  = 1'b0;

  always #10 wrClk = ~wrClk;   // 50 MHz
  always #17 wkClk = ~wkClk;   // slower worker clock

  startDoneXing #(.TASK_LEN(LEN)) u_startDoneXing (
    .wrClk(wrClk), .wkClk(wkClk), .rstN(rstN),
    .wrStb(wrStb), .wrBit(wrBit),
    .busy(busy), .startPulse(startPulse), .taskRun(taskRun)
  );

  // count start pulses and flag any pulse wider than one cycle
  always begin
    @(posedge wkClk);
    #0.5;
    if (startPulse) pulses++;
    if (startPulse && prevPulse) wideErr++;
    prevPulse = startPulse;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic tReset();
    #5;
    chk(busy == 0, "R1 busy in reset", busy, 0);
    chk(startPulse == 0 && taskRun == 0, "R1 worker outputs in reset",
        {startPulse, taskRun}, 0);
    repeat (4) @(negedge wrClk);
    #4 rstN = 1'b1;
    repeat (3) @(negedge wrClk);
    chk(busy == 0, "R1 busy after release", busy, 0);
  endtask

  task automatic tWriteZero();
    int p0 = pulses;
    @(negedge wrClk); wrStb = 1'b1; wrBit = 1'b0;
    @(negedge wrClk); wrStb = 1'b0;
    chk(busy == 0, "R3 busy after write of 0", busy, 0);
    repeat (12) @(negedge wrClk);
    chk(pulses == p0, "R3 no start after write of 0", pulses - p0, 0);
  endtask

  // full transaction with latency, length and turnaround checks
  task automatic tSingle(input string ph);
    int p0 = pulses;
    int n = 0;
    int r = 0;
    int k = 0;
    bit seen = 1'b0;
    @(negedge wrClk); wrStb = 1'b1; wrBit = 1'b1;
    @(posedge wrClk);
    fork begin @(negedge wrClk); wrStb = 1'b0; wrBit = 1'b0; end join_none
    while (n < 10) begin
      @(posedge wkClk); #0.5; n++;
      if (n == 1) chk(busy == 1, {"R2 busy after write ", ph}, busy, 1);
      if (startPulse) break;
    end
    chk(n == 2, {"R4 start latency ", ph}, n, 2);
    while (r < 100) begin
      @(posedge wkClk); #0.5;
      if (taskRun) begin seen = 1'b1; r++; end
      else if (seen) break;
    end
    chk(r == LEN, {"R5 task length ", ph}, r, LEN);
    chk(busy == 1, {"R6 busy held at task end ", ph}, busy, 1);
    while (busy && k < 40) begin
      @(posedge wrClk); #0.5; k++;
    end
    chk(!busy && k <= 20, {"R8 busy turnaround ", ph}, k, 20);
    chk(pulses - p0 == 1, {"R4 one pulse ", ph}, pulses - p0, 1);
    chk(wideErr == 0, {"R4 pulse width ", ph}, wideErr, 0);
  endtask

  task automatic tWriteWhileBusy();
    int p0 = pulses;
    int guard = 0;
    @(negedge wrClk); wrStb = 1'b1; wrBit = 1'b1;
    @(negedge wrClk);
    while (busy && guard < 200) begin
      wrStb = 1'b1; wrBit = 1'b1;
      @(negedge wrClk); guard++;
    end
    wrStb = 1'b0; wrBit = 1'b0;
    repeat (40) @(negedge wrClk);
    chk(pulses - p0 == 1, "R7 extra writes ignored", pulses - p0, 1);
    chk(busy == 0, "R7 busy stays low", busy, 0);
  endtask

  task automatic tResetMidTask();
    int guard = 0;
    @(negedge wrClk); wrStb = 1'b1; wrBit = 1'b1;
    @(negedge wrClk); wrStb = 1'b0; wrBit = 1'b0;
    while (!taskRun && guard < 50) begin
      @(posedge wkClk); #0.5; guard++;
    end
    chk(taskRun == 1, "R9 task running before reset", taskRun, 1);
    #3 rstN = 1'b0;
    #0.5;
    chk(busy == 0, "R9 busy cleared by reset", busy, 0);
    chk(taskRun == 0, "R9 task cleared by reset", taskRun, 0);
    repeat (3) @(negedge wrClk);
    #4 rstN = 1'b1;
    repeat (4) @(negedge wrClk);
    chk(busy == 0 && taskRun == 0, "R9 idle after release", {busy, taskRun}, 0);
  endtask

  initial begin
    tReset();
    tWriteZero();
    tSingle("first");
    tSingle("second");
    tWriteWhileBusy();
    tResetMidTask();
    tSingle("after reset");
    repeat (5) @(negedge wrClk);
    finish();
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

endmodule